// File: doc/BRIEF.md
# Dual-Path Byte/Word Data Memory

This block is a 16-bit-wide data memory whose effective addresses are 16-bit byte addresses. The storage is two byte-wide halves that share one word-address decoder but each has its own write strobe, so a byte store touches only one half. A general path (X) can read and write bytes or words. A second path (Y) serves word reads only, as used by dual-operand arithmetic that fetches two words per cycle.

A byte read fetches the whole containing word and moves the addressed byte onto the low lane of the read data, with the upper lane cleared. Each path has its own implemented address window, set by parameters. Any access that the selected path cannot serve (outside its window, a byte or write request on Y, or a word request at an odd address) raises a one-cycle trap pulse. Refused reads return zero and refused writes leave memory untouched. A small helper presents the post-incremented pointer, stepped by the operand size.

An access is presented for one cycle with `acc_en` high. Read data and the trap pulse appear in the following cycle.

Top module: `dual_path_dmem`

## Requirements
- R1: An X word write at an even address stores `wdata[15:0]`, and an X word read of that address returns the full word on `rdata` in the cycle after the access.
- R2: An X byte write takes its data from `wdata[7:0]`. At an even address it updates only the low half (bits 7:0) of the word, and at an odd address it updates only the high half (bits 15:8). The other half keeps its value.
- R3: An X byte read returns the addressed byte on `rdata[7:0]` with `rdata[15:8]` = 0. The byte comes from bits 7:0 of the word for an even address and from bits 15:8 for an odd address.
- R4: A Y word read (`path_y`=1, `is_byte`=0, `we`=0) at an even address inside the Y window returns the stored word.
- R5: A byte read on the Y path returns 0x0000 and raises the trap.
- R6: A read outside the selected path's window (X window 0x0000..0x00FF, Y window 0x0080..0x00FF by default) returns 0x0000 and raises the trap.
- R7: A write that is refused (outside the X window, or any write on the Y path) changes no memory contents and raises the trap.
- R8: A word access at an odd address raises the trap. A read ignores the address LSb and returns the aligned word, and a write is suppressed.
- R9: `trap` is high for exactly the cycle after a refused access. It is low after a legal access and after any cycle without an access.
- R10: `ea_post` equals `ea + 1` when `is_byte`=1 and `ea + 2` when `is_byte`=0, modulo 2^16. It is combinational.
- R11: During reset and after reset, before any access, `rdata` = 0x0000 and `trap` = 0.
- R12: `rdata` holds its value in every cycle that follows a cycle with no read access. Idle cycles and writes count as no read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_en | input | 1 | Access strobe for this cycle |
| path_y | input | 1 | 0 selects the X path, 1 selects the Y path |
| is_byte | input | 1 | 1 selects a byte operand, 0 selects a word operand |
| we | input | 1 | 1 requests a write, 0 requests a read |
| ea | input | 16 | Effective byte address |
| wdata | input | 16 | Write data (a byte write uses bits 7:0) |
| rdata | output | 16 | Read data, valid the cycle after a read access |
| trap | output | 1 | One-cycle address-error pulse |
| ea_post | output | 16 | Pointer after post-increment by the operand size |

## Verification
The bench fills the array and then sweeps every byte and word address on both paths. This exposes a steering mux that swaps lanes or leaves stale bits in the upper lane. It also exposes a byte strobe that writes both halves and corrupts the neighbouring byte. Out-of-window reads at 0x0100 and above alias to low word indices if the range check is weak, so a broken check returns stored data instead of zero. Refused writes are aimed at those aliases so that a leaky strobe shows up as corrupted contents. Odd-address word accesses and Y-path byte and write requests are checked for both the trap and the data. The pointer helper is checked across the address space, including wrap at 0xFFFF, to catch a step that ignores the operand size.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  // Reason an access is refused; FLT_NONE means the access is legal.
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_RANGE  = 3'd1,
    FLT_YBYTE  = 3'd2,
    FLT_YWRITE = 3'd3,
    FLT_ALIGN  = 3'd4
  } fault_e;

  // Refusals whose read data is forced to zero (alignment refusals still
  // deliver the aligned word).
  function automatic logic fault_zeroes(fault_e f);
    return (f == FLT_RANGE) || (f == FLT_YBYTE) || (f == FLT_YWRITE);
  endfunction

endpackage

// File: rtl/dpm_addr_check.sv
module dpm_addr_check
  import dpm_pkg::*;
#(
  parameter int unsigned EA_W = 16,
  parameter int unsigned IDX_W = 7,
  parameter logic [EA_W-1:0] X_LO = '0,
  parameter logic [EA_W-1:0] X_HI = '1,
  parameter logic [EA_W-1:0] Y_LO = '0,
  parameter logic [EA_W-1:0] Y_HI = '1
) (
  input  logic [EA_W-1:0]  ea,
  input  logic             path_y,
  input  logic             is_byte,
  input  logic             we,
  output fault_e           fault,
  output logic [IDX_W-1:0] widx
);

  localparam logic [EA_W-1:0] X_SPAN = X_HI - X_LO;
  localparam logic [EA_W-1:0] Y_SPAN = Y_HI - Y_LO;

  logic [EA_W-1:0] x_off;
  logic [EA_W-1:0] y_off;
  logic            in_x;
  logic            in_y;

  // Window test by offset: a single unsigned compare per window.
  always_comb begin
    x_off = ea - X_LO;
    y_off = ea - Y_LO;
    in_x  = (x_off <= X_SPAN);
    in_y  = (y_off <= Y_SPAN);
  end

  // Refusal priority: path capability, then window, then alignment.
  always_comb begin
    fault = FLT_NONE;
    if (path_y) begin
      if (we)                  fault = FLT_YWRITE;
      else if (is_byte)        fault = FLT_YBYTE;
      else if (!in_y)          fault = FLT_RANGE;
      else if (ea[0])          fault = FLT_ALIGN;
    end else begin
      if (!in_x)               fault = FLT_RANGE;
      else if (!is_byte && ea[0]) fault = FLT_ALIGN;
    end
  end

  // Shared word decode: the byte-select bit is dropped.
  assign widx = ea[IDX_W:1];

endmodule

// File: rtl/dpm_byte_array.sv
module dpm_byte_array #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        widx,
  input  logic [LANES-1:0]        wstrb,
  input  logic [LANES*LANE_W-1:0] wlane,
  output logic [LANES*LANE_W-1:0] rword
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_d;
    logic [LANE_W-1:0] rd_q;

    // Storage: one write strobe per half, shared word index.
    always_ff @(posedge clk) begin
      if (wstrb[g]) begin
        mem[widx] <= wlane[g*LANE_W +: LANE_W];
      end
    end

    always_comb begin
      rd_d = rd_q;
      if (rd_en) begin
        rd_d = mem[widx];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q <= '0;
      end else begin
        rd_q <= rd_d;
      end
    end

    assign rword[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/dpm_lane_steer.sv
module dpm_lane_steer #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [2*LANE_W-1:0] rword,
  input  logic                byte_q,
  input  logic                odd_q,
  input  logic                zero_q,
  output logic [2*LANE_W-1:0] rdata
);

  always_comb begin
    if (zero_q) begin
      rdata = '0;
    end else if (byte_q) begin
      rdata = {{LANE_W{1'b0}}, (odd_q ? rword[2*LANE_W-1:LANE_W] : rword[LANE_W-1:0])};
    end else begin
      rdata = rword;
    end
  end

endmodule

// File: rtl/dpm_post_mod.sv
module dpm_post_mod #(
  parameter int unsigned EA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EA_W-1:0] ea,
  input  logic            is_byte,
  output logic [EA_W-1:0] ea_post
);

  localparam logic [EA_W-1:0] STEP_BYTE = EA_W'(1);
  localparam logic [EA_W-1:0] STEP_WORD = EA_W'(2);

  always_comb begin
    ea_post = ea + (is_byte ? STEP_BYTE : STEP_WORD);
  end

  // R10: a byte step flips the LSb, a word step keeps it.
  a_r10_step_parity: assert property (@(posedge clk) disable iff (!rst_n)
    ea_post[0] == (ea[0] ^ is_byte));

endmodule

// File: rtl/dual_path_dmem.sv
module dual_path_dmem
  import dpm_pkg::*;
#(
  parameter int unsigned EA_W        = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned DEPTH_WORDS = 128,
  parameter logic [EA_W-1:0] X_LO    = 16'h0000,
  parameter logic [EA_W-1:0] X_HI    = 16'h00FF,
  parameter logic [EA_W-1:0] Y_LO    = 16'h0080,
  parameter logic [EA_W-1:0] Y_HI    = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              path_y,
  input  logic              is_byte,
  input  logic              we,
  input  logic [EA_W-1:0]   ea,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              trap,
  output logic [EA_W-1:0]   ea_post
);

  localparam int unsigned LANES  = 2;
  localparam int unsigned BYTE_W = DATA_W / LANES;
  localparam int unsigned IDX_W  = $clog2(DEPTH_WORDS);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta;
  logic rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  // Address decode and refusal classification.
  fault_e           fault;
  logic [IDX_W-1:0] widx;

  dpm_addr_check #(
    .EA_W (EA_W),
    .IDX_W(IDX_W),
    .X_LO (X_LO),
    .X_HI (X_HI),
    .Y_LO (Y_LO),
    .Y_HI (Y_HI)
  ) u_check (
    .ea     (ea),
    .path_y (path_y),
    .is_byte(is_byte),
    .we     (we),
    .fault  (fault),
    .widx   (widx)
  );

  // Write lanes: a byte store replicates wdata[7:0] onto both halves and
  // the strobe picks the half.
  logic [DATA_W-1:0] wlane;
  logic [LANES-1:0]  wstrb;
  logic              rd_en;
  logic              legal;

  for (genvar g = 0; g < LANES; g++) begin : g_wlane
    assign wlane[g*BYTE_W +: BYTE_W] = is_byte ? wdata[BYTE_W-1:0]
                                               : wdata[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    legal = (fault == FLT_NONE);
    rd_en = acc_en && !we;
    wstrb = '0;
    if (acc_en && we && legal) begin
      if (is_byte) begin
        wstrb = ea[0] ? 2'b10 : 2'b01;
      end else begin
        wstrb = 2'b11;
      end
    end
  end

  logic [DATA_W-1:0] rword;

  dpm_byte_array #(
    .LANE_W(BYTE_W),
    .LANES (LANES),
    .DEPTH (DEPTH_WORDS),
    .IDX_W (IDX_W)
  ) u_array (
    .clk  (clk),
    .rst_n(rst_s_n),
    .rd_en(rd_en),
    .widx (widx),
    .wstrb(wstrb),
    .wlane(wlane),
    .rword(rword)
  );

  // Read-side control captured alongside the array read.
  logic byte_d, odd_d, zero_d, trap_d;
  logic byte_q, odd_q, zero_q, trap_q;

  always_comb begin
    byte_d = byte_q;
    odd_d  = odd_q;
    zero_d = zero_q;
    if (rd_en) begin
      byte_d = is_byte;
      odd_d  = ea[0];
      zero_d = fault_zeroes(fault);
    end
    trap_d = acc_en && !legal;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      byte_q <= 1'b0;
      odd_q  <= 1'b0;
      zero_q <= 1'b1;
      trap_q <= 1'b0;
    end else begin
      byte_q <= byte_d;
      odd_q  <= odd_d;
      zero_q <= zero_d;
      trap_q <= trap_d;
    end
  end

  dpm_lane_steer #(
    .LANE_W(BYTE_W)
  ) u_steer (
    .rword (rword),
    .byte_q(byte_q),
    .odd_q (odd_q),
    .zero_q(zero_q),
    .rdata (rdata)
  );

  assign trap = trap_q;

  dpm_post_mod #(
    .EA_W(EA_W)
  ) u_post (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .ea     (ea),
    .is_byte(is_byte),
    .ea_post(ea_post)
  );

  // R9: no access, no trap in the next cycle.
  a_r9_idle_no_trap: assert property (@(posedge clk) disable iff (!rst_s_n)
    !acc_en |=> !trap);

  // R5/R6: refused reads come back as zero.
  a_r6_zero_read: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_en && !we && fault_zeroes(fault)) |=> (rdata == '0));

  // R3: legal byte reads clear the upper lane.
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_en && !we && is_byte && fault == FLT_NONE) |=> (rdata[DATA_W-1:BYTE_W] == '0));

  // R2: a byte write drives at most one half.
  a_r2_single_half: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_en && we && is_byte) |-> ($countones(wstrb) <= 1));

  // R8: odd-address word access traps.
  a_r8_align_trap: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc_en && !is_byte && ea[0]) |=> trap);

  // R12: without a read access the read data holds.
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(acc_en && !we) |=> $stable(rdata));

endmodule

// File: tb/dual_path_dmem_tb_top.sv
module dual_path_dmem_tb_top;

  logic        clk;
  logic        rst_n;
  logic        acc_en;
  logic        path_y;
  logic        is_byte;
  logic        we;
  logic [15:0] ea;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        trap;
  logic [15:0] ea_post;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] model [256];

  dual_path_dmem dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_en (acc_en),
    .path_y (path_y),
    .is_byte(is_byte),
    .we     (we),
    .ea     (ea),
    .wdata  (wdata),
    .rdata  (rdata),
    .trap   (trap),
    .ea_post(ea_post)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit in_x(input logic [15:0] a);
    return a <= 16'h00FF;
  endfunction

  function automatic bit in_y(input logic [15:0] a);
    return (a >= 16'h0080) && (a <= 16'h00FF);
  endfunction

  function automatic bit exp_trap(input bit py, input bit ib, input bit w,
                                  input logic [15:0] a);
    if (py) return w || ib || !in_y(a) || a[0];
    return !in_x(a) || (!ib && a[0]);
  endfunction

  function automatic logic [15:0] exp_read(input bit py, input bit ib,
                                           input logic [15:0] a);
    if (py && ib) return 16'h0000;
    if (py ? !in_y(a) : !in_x(a)) return 16'h0000;
    if (ib) return {8'h00, model[a[7:0]]};
    return {model[{a[7:1], 1'b1}], model[{a[7:1], 1'b0}]};
  endfunction

  // One access cycle; outputs are sampled by the caller at the next negedge.
  task automatic acc(input bit py, input bit ib, input bit w,
                     input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    path_y  = py;
    is_byte = ib;
    we      = w;
    ea      = a;
    wdata   = d;
    acc_en  = 1'b1;
    @(negedge clk);
    acc_en  = 1'b0;
  endtask

  task automatic do_read(input bit py, input bit ib, input logic [15:0] a,
                         input string req);
    logic [15:0] e;
    bit t;
    e = exp_read(py, ib, a);
    t = exp_trap(py, ib, 1'b0, a);
    acc(py, ib, 1'b0, a, 16'h0000);
    chk(rdata == e, req, rdata, e);
    chk(trap == t, {req, " trap"}, {15'd0, trap}, {15'd0, t});
  endtask

  task automatic do_write(input bit py, input bit ib, input logic [15:0] a,
                          input logic [15:0] d, input string req);
    bit t;
    t = exp_trap(py, ib, 1'b1, a);
    acc(py, ib, 1'b1, a, d);
    chk(trap == t, {req, " trap"}, {15'd0, trap}, {15'd0, t});
    if (!t) begin
      if (ib) begin
        model[a[7:0]] = d[7:0];
      end else begin
        model[{a[7:1], 1'b0}] = d[7:0];
        model[{a[7:1], 1'b1}] = d[15:8];
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    rst_n   = 1'b0;
    acc_en  = 1'b0;
    path_y  = 1'b0;
    is_byte = 1'b0;
    we      = 1'b0;
    ea      = '0;
    wdata   = '0;
    repeat (3) @(negedge clk);
    chk(rdata == 16'h0000, "R11 rdata in reset", rdata, 16'h0000);
    chk(trap == 1'b0, "R11 trap in reset", {15'd0, trap}, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdata == 16'h0000, "R11 rdata after reset", rdata, 16'h0000);
    chk(trap == 1'b0, "R11 trap after reset", {15'd0, trap}, 16'h0000);

    // R1: fill every word via X word writes.
    for (int i = 0; i < 128; i++) begin
      logic [15:0] p;
      p = 16'(i * 16'h9E37) ^ 16'h1234;
      do_write(1'b0, 1'b0, 16'(2 * i), p, "R1 word write");
    end
    for (int a = 0; a < 256; a += 2) do_read(1'b0, 1'b0, 16'(a), "R1 X word read");

    // R3: byte reads at every address.
    for (int a = 0; a < 256; a++) do_read(1'b0, 1'b1, 16'(a), "R3 X byte read");

    // R2: byte writes, then the containing word shows the other half intact.
    for (int a = 0; a < 256; a += 3) begin
      do_write(1'b0, 1'b1, 16'(a), {8'hEE, 8'(a * 7 + 1)}, "R2 byte write");
      do_read(1'b0, 1'b0, 16'({a[15:1], 1'b0}), "R2 other half kept");
    end

    // R4: Y word reads across its window.
    for (int a = 16'h80; a < 256; a += 2) do_read(1'b1, 1'b0, 16'(a), "R4 Y word read");

    // R5: Y byte reads are refused.
    for (int a = 16'h80; a < 256; a += 17) do_read(1'b1, 1'b1, 16'(a), "R5 Y byte read");

    // R6: reads outside each window.
    for (int a = 0; a < 16'h80; a += 6) do_read(1'b1, 1'b0, 16'(a), "R6 Y below window");
    for (int a = 16'h100; a < 16'h200; a += 2) do_read(1'b0, 1'b0, 16'(a), "R6 X above window");
    do_read(1'b0, 1'b1, 16'h8000, "R6 X far byte");
    do_read(1'b0, 1'b0, 16'hFFFE, "R6 X top word");
    do_read(1'b1, 1'b0, 16'h0100, "R6 Y above window");

    // R7: refused writes leave the aliased words unchanged.
    do_write(1'b0, 1'b0, 16'h0100, 16'hDEAD, "R7 X out-of-window write");
    do_write(1'b0, 1'b1, 16'h0181, 16'h00BE, "R7 X out-of-window byte write");
    do_write(1'b1, 1'b0, 16'h0080, 16'hBEEF, "R7 Y write");
    do_write(1'b1, 1'b1, 16'h0091, 16'h0055, "R7 Y byte write");
    do_read(1'b0, 1'b0, 16'h0000, "R7 alias 0x0000 intact");
    do_read(1'b0, 1'b0, 16'h0080, "R7 word 0x0080 intact");
    do_read(1'b0, 1'b0, 16'h0090, "R7 word 0x0090 intact");

    // R8: odd-address word accesses.
    do_read(1'b0, 1'b0, 16'h0021, "R8 X odd word read");
    chk(rdata == exp_read(1'b0, 1'b0, 16'h0020), "R8 X aligned data", rdata,
        exp_read(1'b0, 1'b0, 16'h0020));
    do_read(1'b1, 1'b0, 16'h0091, "R8 Y odd word read");
    chk(rdata == exp_read(1'b1, 1'b0, 16'h0090), "R8 Y aligned data", rdata,
        exp_read(1'b1, 1'b0, 16'h0090));
    do_write(1'b0, 1'b0, 16'h0011, 16'hCAFE, "R8 X odd word write");
    do_read(1'b0, 1'b0, 16'h0010, "R8 odd write suppressed");

    // R9: trap lasts one cycle.
    acc(1'b0, 1'b0, 1'b0, 16'h0300, 16'h0000);
    chk(trap == 1'b1, "R9 trap raised", {15'd0, trap}, 16'h0001);
    @(negedge clk);
    chk(trap == 1'b0, "R9 trap cleared", {15'd0, trap}, 16'h0000);
    acc(1'b0, 1'b1, 1'b0, 16'h0005, 16'h0000);
    chk(trap == 1'b0, "R9 legal no trap", {15'd0, trap}, 16'h0000);

    // R12: read data holds across idle cycles and writes.
    do_read(1'b0, 1'b0, 16'h0042, "R12 setup read");
    held = rdata;
    repeat (3) @(negedge clk);
    chk(rdata == held, "R12 hold idle", rdata, held);
    do_write(1'b0, 1'b0, 16'h0044, 16'h7777, "R12 write");
    chk(rdata == held, "R12 hold over write", rdata, held);

    // R10: pointer post-increment.
    for (int a = 0; a < 65536; a += 251) begin
      for (int b = 0; b < 2; b++) begin
        logic [15:0] e;
        @(negedge clk);
        ea = 16'(a);
        is_byte = b[0];
        #1;
        e = 16'(a + (b == 1 ? 1 : 2));
        chk(ea_post == e, "R10 post step", ea_post, e);
      end
    end
    @(negedge clk);
    ea = 16'hFFFF; is_byte = 1'b1; #1;
    chk(ea_post == 16'h0000, "R10 byte wrap", ea_post, 16'h0000);
    ea = 16'hFFFF; is_byte = 1'b0; #1;
    chk(ea_post == 16'h0001, "R10 word wrap", ea_post, 16'h0001);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule